// File: doc/BRIEF.md
# Dual-Reload PWM Timer Channel

This block is one output channel of a timer. A down-counter alternates between two programmed reload values and flips an output flip-flop each time a phase runs out. Phase 0 takes its length from the first reload register and phase 1 from the second. The result is a PWM wave whose two half-periods are set independently. The counter advances only on cycles where the count-clock tick is high. Every load puts the reload value minus one into the counter. A phase therefore lasts exactly as many ticks as its reload value.

In continuous mode the two phases repeat until the channel is disabled. In single-shot mode the channel runs phase 0 and then phase 1 once, stops, and holds its output until the enable is lowered and raised again. A reload value of all ones keeps the flip-flop from flipping at the end of that phase, which allows constant 0% or 100% outputs. Reload writes go to the registers only. The counter sees a new value at its next load.

The control state machine has four states. `S_IDLE` is the disabled state. `S_PH0` is the phase counted from reload 0 and `S_PH1` is the phase counted from reload 1. `S_HALT` means a single shot has finished. Transitions:
- idle-to-phase0: enabled and ticking, load reload 0 − 1.
- phase0-to-phase1: underflow, load reload 1 − 1.
- phase1-to-phase0: underflow in continuous mode, load reload 0 − 1.
- phase1-to-halt: underflow in single-shot mode.
- any-to-idle: enable low. This freezes the counter.

Top module: `pwm_dual_reload_timer`

## Requirements
- R1: After reset `out_level` and `underflow` are 0 and the channel is idle.
- R2: With `tick` high every cycle, the first tick with `chan_en` high loads reload 0 − 1. `out_level` first changes after the (reload0+1)-th rising edge with `chan_en` high.
- R3: In continuous mode (`single_shot`=0) the output alternates between a phase of reload0 ticks and a phase of reload1 ticks.
- R4: Each phase end raises `underflow` for one clock cycle. Any change of `out_level` happens on the same edge as an `underflow` pulse, and only on a ticking cycle.
- R5: The counter changes only on cycles with `tick` high. Ticking every second cycle doubles every phase length.
- R6: `wr_en` writes `wr_data` to reload 0 when `wr_sel`=0 and to reload 1 when `wr_sel`=1. A write leaves the running phase unchanged and takes effect at the next load of that register.
- R7: A reload value of all ones still ends its phase with an `underflow` pulse, but `out_level` does not flip at that phase end.
- R8: In single-shot mode the channel runs one phase 0 and one phase 1, then holds `out_level` with no further underflows. Lowering and raising `chan_en` starts a new shot.
- R9: While `chan_en` is low the counter is frozen, `out_level` holds and no underflow occurs. Re-enabling restarts with a load of reload 0 − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count-clock enable |
| chan_en | input | 1 | Channel enable |
| single_shot | input | 1 | 1 selects single-shot mode, 0 selects continuous mode |
| wr_en | input | 1 | Reload register write strobe |
| wr_sel | input | 1 | 0 selects reload 0, 1 selects reload 1 |
| wr_data | input | CNT_W | Reload write value |
| out_level | output | 1 | PWM flip-flop output |
| underflow | output | 1 | One-cycle pulse at each phase end |

## Verification
The bench builds the channel with `CNT_W` = 8 rather than the default 16. With that width the all-ones reload phase lasts 255 ticks, so both the 0%-duty case and the case where only one phase suppresses the flip can be observed to completion in a few hundred cycles. Short reload values, including 1, are covered under full-rate and half-rate ticking. Phase widths are measured as cycle distances between output edges.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_PH0  = 2'd1,
        S_PH1  = 2'd2,
        S_HALT = 2'd3
    } tmr_state_e;
endpackage

// File: rtl/pwm_reload_bank.sv
module pwm_reload_bank #(
    parameter int W     = 16,
    parameter int N_REG = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rl0,
    output logic [W-1:0] rl1
);
    logic [W-1:0] rl_q [N_REG];

    for (genvar g = 0; g < N_REG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                rl_q[g] <= '0;
            else if (wr_en && (int'(wr_sel) == g))
                rl_q[g] <= wr_data;
        end
    end

    assign rl0 = rl_q[0];
    assign rl1 = rl_q[1];
endmodule

// File: rtl/pwm_down_counter.sv
module pwm_down_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec)
            cnt_q <= cnt_q - 1'b1;
    end

    assign cnt  = cnt_q;
    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pwm_phase_fsm.sv
module pwm_phase_fsm
    import pwm_tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         chan_en,
    input  logic         single_shot,
    input  logic         zero,
    input  logic [W-1:0] rl0,
    input  logic [W-1:0] rl1,
    output logic         load,
    output logic [W-1:0] load_val,
    output logic         dec,
    output logic         out_level,
    output logic         underflow
);
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] ALL1 = {W{1'b1}};

    tmr_state_e state_q, state_d;
    logic       skip_q, skip_d;
    logic       fire, tog;
    logic       out_q, uf_q;

    always_comb begin
        state_d  = state_q;
        skip_d   = skip_q;
        load     = 1'b0;
        load_val = rl0 - ONE;
        dec      = 1'b0;
        fire     = 1'b0;
        tog      = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (chan_en && tick) begin
                    load    = 1'b1;
                    skip_d  = (rl0 == ALL1);
                    state_d = S_PH0;
                end
            end
            S_PH0: begin
                if (!chan_en) begin
                    state_d = S_IDLE;
                end else if (tick) begin
                    if (zero) begin
                        fire     = 1'b1;
                        tog      = !skip_q;
                        load     = 1'b1;
                        load_val = rl1 - ONE;
                        skip_d   = (rl1 == ALL1);
                        state_d  = S_PH1;
                    end else begin
                        dec = 1'b1;
                    end
                end
            end
            S_PH1: begin
                if (!chan_en) begin
                    state_d = S_IDLE;
                end else if (tick) begin
                    if (zero) begin
                        fire = 1'b1;
                        tog  = !skip_q;
                        if (single_shot) begin
                            state_d = S_HALT;
                        end else begin
                            load    = 1'b1;
                            skip_d  = (rl0 == ALL1);
                            state_d = S_PH0;
                        end
                    end else begin
                        dec = 1'b1;
                    end
                end
            end
            S_HALT: begin
                if (!chan_en)
                    state_d = S_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            skip_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            skip_q  <= skip_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
            uf_q  <= 1'b0;
        end else begin
            out_q <= out_q ^ tog;
            uf_q  <= fire;
        end
    end

    assign out_level = out_q;
    assign underflow = uf_q;

    assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HALT) |=> ($stable(out_q) && !uf_q));

    assert_allones_no_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && skip_q) |=> $stable(out_q));
endmodule

// File: rtl/pwm_dual_reload_timer.sv
module pwm_dual_reload_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             chan_en,
    input  logic             single_shot,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             out_level,
    output logic             underflow
);
    logic [CNT_W-1:0] rl0, rl1, load_val, cnt;
    logic             load, dec, zero;

    pwm_reload_bank #(.W(CNT_W), .N_REG(2)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rl0(rl0), .rl1(rl1)
    );

    pwm_down_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .dec(dec), .cnt(cnt), .zero(zero)
    );

    pwm_phase_fsm #(.W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .chan_en(chan_en),
        .single_shot(single_shot), .zero(zero), .rl0(rl0), .rl1(rl1),
        .load(load), .load_val(load_val), .dec(dec),
        .out_level(out_level), .underflow(underflow)
    );

    assert_cnt_hold_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

    assert_freeze_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> ($stable(cnt) && !underflow));

    assert_flip_with_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_level) |-> underflow);

    assert_pulse_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> $past(tick));
endmodule

// File: tb/pwm_dual_reload_timer_tb.sv
module pwm_dual_reload_timer_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         chan_en = 1'b0;
    logic         single_shot = 1'b0;
    logic         wr_en = 1'b0;
    logic         wr_sel = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         out_level, underflow;

    pwm_dual_reload_timer #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .chan_en(chan_en),
        .single_shot(single_shot), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .out_level(out_level), .underflow(underflow)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int div = 1;
    int en_stamp = 0;
    int edges [0:63];
    int n_edge = 0, n_uf = 0, n_orphan = 0;
    logic prev_out = 1'b0;
    logic mon_on = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        tick <= (div == 1) || (cyc % 2 == 0);
        if (mon_on) begin
            if (out_level !== prev_out) begin
                if (n_edge < 64) edges[n_edge] = cyc;
                n_edge++;
                if (!underflow) n_orphan++;
            end
            if (underflow) n_uf++;
        end
        prev_out = out_level;
    end

    task automatic check_eq(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_rl(logic sel, int val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = W'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_mon();
        n_edge = 0; n_uf = 0; n_orphan = 0;
    endtask

    task automatic start();
        @(negedge clk);
        chan_en = 1'b1;
        en_stamp = cyc;
    endtask

    task automatic stop();
        @(negedge clk);
        chan_en = 1'b0;
        wait_n(2);
    endtask

    // {reload0, reload1, tick divider}
    localparam int VEC [0:4][0:2] = '{
        '{3, 5, 1}, '{1, 1, 1}, '{7, 2, 1}, '{10, 4, 2}, '{2, 9, 2}
    };

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic lvl;
        wait_n(3);
        // R1: reset values
        check_eq("R1 out_level in reset", int'(out_level), 0);
        check_eq("R1 underflow in reset", int'(underflow), 0);
        rst_n = 1'b1;
        wait_n(2);
        check_eq("R1 out_level after reset", int'(out_level), 0);
        check_eq("R1 underflow after reset", int'(underflow), 0);
        mon_on = 1'b1;

        // Vector table: R2, R3, R4, R5
        for (int i = 0; i < 5; i++) begin
            stop();
            div = VEC[i][2];
            write_rl(1'b0, VEC[i][0]);
            write_rl(1'b1, VEC[i][1]);
            wait_n(2);
            clear_mon();
            start();
            wait_n((2 * VEC[i][0] + VEC[i][1] + 4) * div + 4);
            check_eq("R3 edges seen", int'(n_edge >= 3), 1);
            if (div == 1)
                check_eq("R2 first flip delay", edges[0] - en_stamp, VEC[i][0] + 1);
            check_eq("R3/R5 phase1 width", edges[1] - edges[0], VEC[i][1] * div);
            check_eq("R3/R5 phase0 width", edges[2] - edges[1], VEC[i][0] * div);
            check_eq("R4 flips without pulse", n_orphan, 0);
            check_eq("R4 pulses vs flips", n_uf, n_edge);
        end

        // R6: write during running phase
        stop();
        div = 1;
        write_rl(1'b0, 20);
        write_rl(1'b1, 3);
        wait_n(2);
        clear_mon();
        start();
        wait_n(5);
        write_rl(1'b0, 2);
        wait_n(40);
        check_eq("R6 running phase kept", edges[0] - en_stamp, 21);
        check_eq("R6 new value later", edges[2] - edges[1], 2);

        // R7: both reloads all ones -> constant output
        stop();
        write_rl(1'b0, 255);
        write_rl(1'b1, 255);
        wait_n(2);
        clear_mon();
        start();
        wait_n(600);
        check_eq("R7 no flips both all-ones", n_edge, 0);
        check_eq("R7 pulses both all-ones", n_uf, 2);

        // R7: only phase 0 all ones
        stop();
        write_rl(1'b1, 3);
        wait_n(2);
        clear_mon();
        start();
        wait_n(262);
        check_eq("R7 flips phase0 all-ones", n_edge, 1);
        check_eq("R7 pulses phase0 all-ones", n_uf, 2);

        // R8: single shot
        stop();
        single_shot = 1'b1;
        write_rl(1'b0, 3);
        write_rl(1'b1, 4);
        wait_n(2);
        lvl = out_level;
        clear_mon();
        start();
        wait_n(40);
        check_eq("R8 shot flips", n_edge, 2);
        check_eq("R8 shot pulses", n_uf, 2);
        check_eq("R8 shot high width", edges[1] - edges[0], 4);
        check_eq("R8 level held after shot", int'(out_level), int'(lvl));
        stop();
        start();
        wait_n(40);
        check_eq("R8 re-armed shot flips", n_edge, 4);

        // R9: disable freezes, re-enable restarts
        stop();
        single_shot = 1'b0;
        write_rl(1'b0, 6);
        write_rl(1'b1, 6);
        wait_n(2);
        clear_mon();
        start();
        wait_n(10);
        stop();
        lvl = out_level;
        clear_mon();
        wait_n(50);
        check_eq("R9 no flips while disabled", n_edge, 0);
        check_eq("R9 no pulses while disabled", n_uf, 0);
        check_eq("R9 level held", int'(out_level), int'(lvl));
        start();
        wait_n(30);
        check_eq("R9 restart loads reload0", edges[0] - en_stamp, 7);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule